// File: doc/BRIEF.md
# Stream-Driven Raster Timing Generator

This block turns a back-pressured pixel stream into an analogue-style raster: separate active-low horizontal and vertical sync pulses and three 8-bit colour channels, all in the pixel clock domain. Both axes run from free-running counters whose active size, porch, sync width and total length come from run-time inputs, 12 bits each. The porch is counted from the end of the active region to the start of sync. The horizontal total is the number of pixel clocks per line, and the vertical total is the number of lines per frame.

During the active area the block takes one beat per clock from the stream and shows it on the next clock. Every beat carries an end-of-line flag and an end-of-frame flag. The block compares the end-of-line flag with its own column counter. If they disagree, it gives up the frame: it discards beats until it has consumed an end-of-frame beat, then waits for its own frame boundary before it accepts pixels again. A stream that is simply not valid during the active area does not stall the raster; those pixels go out black.

Any change on the timing inputs restarts the raster from its origin, exactly as a reset does.

Top module: `vga_stream_timer`

## Requirements
- R1: The column counter runs 0 to h_total-1 and then wraps to 0. The line counter advances once per column wrap and runs 0 to v_total-1. The first clock after reset is column 0 of line 0.
- R2: Colour and sync outputs are registered, so the value for clock slot k appears on the next clock. hsync_n is low for the slots whose column lies in [h_active+h_porch, h_active+h_porch+h_sync-1], and high for all other slots.
- R3: vsync_n is low for the slots whose line lies in [v_active+v_porch, v_active+v_porch+v_sync-1], and high for all other slots.
- R4: When the block is locked, s_ready is high exactly in the slots whose column is below h_active and whose line is below v_active. A beat accepted in such a slot appears on red (s_rgb[23:16]), grn (s_rgb[15:8]) and blu (s_rgb[7:0]) on the next clock.
- R5: The colour outputs are zero for every slot in which no beat was shown, including all blanking slots.
- R6: If s_valid is low during an active slot, that slot is shown black and both counters keep running without a stall.
- R7: In a locked active slot, an accepted beat whose s_eol differs from (column == h_active-1) is still shown. From the next slot onward the block discards stream beats, with s_ready high in every slot and the colour outputs zero, until it consumes a beat with s_eof set. A mismatching beat that itself carries s_eof skips the discard step.
- R8: After that end-of-frame beat, s_ready stays low until the slot at column 0, line 0. Normal locked operation resumes in that slot.
- R9: If any timing input differs from its value on the previous clock, s_ready is low in that slot and the next slot is column 0 of line 0, in the locked state, with idle outputs.
- R10: While rst is high, s_ready is low. On the clock after a reset edge, hsync_n and vsync_n are high and the colour outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| h_active | input | 12 | Visible columns per line |
| h_porch | input | 12 | Columns from end of active to start of hsync |
| h_sync | input | 12 | Width of hsync in columns |
| h_total | input | 12 | Pixel clocks per line |
| v_active | input | 12 | Visible lines per frame |
| v_porch | input | 12 | Lines from end of active to start of vsync |
| v_sync | input | 12 | Width of vsync in lines |
| v_total | input | 12 | Lines per frame |
| s_valid | input | 1 | Stream beat valid |
| s_ready | output | 1 | Block accepts a beat this clock |
| s_rgb | input | 24 | Pixel: red [23:16], green [15:8], blue [7:0] |
| s_eol | input | 1 | Beat is the last of its line |
| s_eof | input | 1 | Beat is the last of its frame |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| red | output | 8 | Red channel |
| grn | output | 8 | Green channel |
| blu | output | 8 | Blue channel |

## Verification
The bench targets a pixel that goes missing in mid-line. A design that stalled its counters there would shift hsync. One that failed to notice the resulting missing end-of-line marker would show the rest of the frame skewed by one column. An end-of-line marker that arrives early is also injected. A design that relocked at once instead of draining to the end-of-frame beat would show wrong pixels. One that kept s_ready high after the drain would swallow the first beats of the next frame. Timing changes at a frame boundary and in mid-frame check that a design carrying old counter values past the change produces sync pulses in the wrong place.

// File: rtl/vst_pkg.sv
package vst_pkg;
    parameter int TW       = 12;   // timing field width
    parameter int CW       = 8;    // bits per colour channel
    parameter int NUM_AXES = 2;
    localparam int AX_H    = 0;
    localparam int AX_V    = 1;
    localparam int PIX_W   = 3 * CW;

    typedef logic [TW-1:0] tcount_t;

    typedef struct packed {
        tcount_t active;
        tcount_t porch;
        tcount_t sync;
        tcount_t total;
    } axis_cfg_t;

    typedef struct packed {
        logic [CW-1:0] r;
        logic [CW-1:0] g;
        logic [CW-1:0] b;
    } rgb_t;

    typedef enum logic [1:0] {
        TRK_LOCKED = 2'd0,
        TRK_DRAIN  = 2'd1,
        TRK_WAIT   = 2'd2
    } trk_state_t;

    // True when cnt lies inside the sync window of one axis.
    function automatic logic in_sync_window(input tcount_t cnt, input axis_cfg_t c);
        logic [TW+1:0] first;
        logic [TW+1:0] stop;
        first = {2'b00, c.active} + {2'b00, c.porch};
        stop  = first + {2'b00, c.sync};
        return ({2'b00, cnt} >= first) && ({2'b00, cnt} < stop);
    endfunction
endpackage

// File: rtl/vst_axis_counter.sv
module vst_axis_counter
    import vst_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      adv,
    input  axis_cfg_t cfg,
    output tcount_t   cnt,
    output logic      at_last,
    output logic      in_active,
    output logic      in_sync
);
    always_comb begin
        at_last   = (cnt >= cfg.total - tcount_t'(1));
        in_active = (cnt < cfg.active);
        in_sync   = in_sync_window(cnt, cfg);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (adv)
            cnt <= at_last ? '0 : cnt + tcount_t'(1);
    end

    // R1
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && at_last) |=> (cnt == '0));
    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !at_last) |=> (cnt == $past(cnt) + tcount_t'(1)));
    // R1
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!adv) |=> $stable(cnt));
endmodule

// File: rtl/vst_stream_track.sv
module vst_stream_track
    import vst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_active,
    input  logic       col_last,
    input  logic       frame_end,
    input  logic       s_valid,
    input  logic       s_eol,
    input  logic       s_eof,
    output logic       s_ready,
    output logic       show,
    output trk_state_t state
);
    logic       accept;
    logic       eol_bad;
    trk_state_t state_nx;

    always_comb begin
        s_ready = !rst && (((state == TRK_LOCKED) && frame_active) || (state == TRK_DRAIN));
        accept  = s_valid && s_ready;
        show    = accept && (state == TRK_LOCKED);
        eol_bad = (s_eol != col_last);
        state_nx = state;
        unique case (state)
            TRK_LOCKED: if (accept && eol_bad) state_nx = s_eof ? TRK_WAIT : TRK_DRAIN;
            TRK_DRAIN:  if (accept && s_eof)   state_nx = TRK_WAIT;
            TRK_WAIT:   if (frame_end)         state_nx = TRK_LOCKED;
            default:                           state_nx = TRK_LOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= TRK_LOCKED;
        else     state <= state_nx;
    end

    // R8
    wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == TRK_WAIT) |-> !s_ready);
    // R7
    drain_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (state == TRK_DRAIN) |-> (s_ready && !show));
    // R4
    ready_region_chk: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> (frame_active || (state == TRK_DRAIN)));
    // R7
    lose_lock_chk: assert property (@(posedge clk) disable iff (rst)
        ((state == TRK_LOCKED) && s_valid && s_ready && (s_eol != col_last))
        |=> (state != TRK_LOCKED));
    // R8
    relock_chk: assert property (@(posedge clk) disable iff (rst)
        ((state == TRK_WAIT) && frame_end) |=> (state == TRK_LOCKED));
endmodule

// File: rtl/vst_pixel_out.sv
module vst_pixel_out
    import vst_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic show,
    input  rgb_t pix,
    input  logic h_sync_on,
    input  logic v_sync_on,
    output logic hsync_n,
    output logic vsync_n,
    output rgb_t rgb
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hsync_n <= 1'b1;
            vsync_n <= 1'b1;
            rgb     <= '0;
        end else begin
            hsync_n <= !h_sync_on;
            vsync_n <= !v_sync_on;
            rgb     <= show ? pix : '0;
        end
    end

    // R5
    blank_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(show)) |-> (rgb == '0));
    // R2
    hsync_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(h_sync_on)) |-> !hsync_n);
    // R2
    hsync_high_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(h_sync_on)) |-> hsync_n);
    // R3
    vsync_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(v_sync_on)) |-> !vsync_n);
endmodule

// File: rtl/vga_stream_timer.sv
module vga_stream_timer
    import vst_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] h_active,
    input  logic [TW-1:0] h_porch,
    input  logic [TW-1:0] h_sync,
    input  logic [TW-1:0] h_total,
    input  logic [TW-1:0] v_active,
    input  logic [TW-1:0] v_porch,
    input  logic [TW-1:0] v_sync,
    input  logic [TW-1:0] v_total,
    input  logic          s_valid,
    output logic          s_ready,
    input  logic [PIX_W-1:0] s_rgb,
    input  logic          s_eol,
    input  logic          s_eof,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic [CW-1:0] red,
    output logic [CW-1:0] grn,
    output logic [CW-1:0] blu
);
    axis_cfg_t             cfg    [NUM_AXES];
    axis_cfg_t             cfg_q  [NUM_AXES];
    tcount_t               cnt    [NUM_AXES];
    logic [NUM_AXES-1:0]   chg_ax;
    logic [NUM_AXES-1:0]   ax_adv;
    logic [NUM_AXES-1:0]   at_last;
    logic [NUM_AXES-1:0]   in_act;
    logic [NUM_AXES-1:0]   in_sync;
    logic                  soft_rst;
    logic                  show;
    trk_state_t            trk_state;
    rgb_t                  rgb_q;

    assign cfg[AX_H] = axis_cfg_t'({h_active, h_porch, h_sync, h_total});
    assign cfg[AX_V] = axis_cfg_t'({v_active, v_porch, v_sync, v_total});

    generate
        for (genvar i = 0; i < NUM_AXES; i++) begin : g_axis
            always_ff @(posedge clk) cfg_q[i] <= cfg[i];
            assign chg_ax[i] = (cfg_q[i] != cfg[i]);

            if (i == 0) begin : g_first
                assign ax_adv[i] = 1'b1;
            end else begin : g_next
                assign ax_adv[i] = ax_adv[i-1] & at_last[i-1];
            end

            vst_axis_counter u_cnt (
                .clk       (clk),
                .rst       (soft_rst),
                .adv       (ax_adv[i]),
                .cfg       (cfg[i]),
                .cnt       (cnt[i]),
                .at_last   (at_last[i]),
                .in_active (in_act[i]),
                .in_sync   (in_sync[i])
            );
        end
    endgenerate

    assign soft_rst = rst || (|chg_ax);

    vst_stream_track u_trk (
        .clk          (clk),
        .rst          (soft_rst),
        .frame_active (&in_act),
        .col_last     (cnt[AX_H] == cfg[AX_H].active - tcount_t'(1)),
        .frame_end    (&at_last),
        .s_valid      (s_valid),
        .s_eol        (s_eol),
        .s_eof        (s_eof),
        .s_ready      (s_ready),
        .show         (show),
        .state        (trk_state)
    );

    vst_pixel_out u_out (
        .clk       (clk),
        .rst       (soft_rst),
        .show      (show),
        .pix       (rgb_t'(s_rgb)),
        .h_sync_on (in_sync[AX_H]),
        .v_sync_on (in_sync[AX_V]),
        .hsync_n   (hsync_n),
        .vsync_n   (vsync_n),
        .rgb       (rgb_q)
    );

    assign red = rgb_q.r;
    assign grn = rgb_q.g;
    assign blu = rgb_q.b;

    // R9
    cfg_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (|chg_ax) |=> ((cnt[AX_H] == '0) && (cnt[AX_V] == '0) && (trk_state == TRK_LOCKED)));
    // R9
    cfg_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (|chg_ax) |-> !s_ready);
    // R10
    rst_quiet_chk: assert property (@(posedge clk)
        rst |-> !s_ready);
endmodule

// File: tb/vga_stream_timer_tb.sv
module vga_stream_timer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] h_active, h_porch, h_sync, h_total;
    logic [11:0] v_active, v_porch, v_sync, v_total;
    logic        s_valid, s_ready, s_eol, s_eof;
    logic [23:0] s_rgb;
    logic        hsync_n, vsync_n;
    logic [7:0]  red, grn, blu;

    always #(CLK_PERIOD/2) clk = ~clk;

    vga_stream_timer u_dut (
        .clk(clk), .rst(rst),
        .h_active(h_active), .h_porch(h_porch), .h_sync(h_sync), .h_total(h_total),
        .v_active(v_active), .v_porch(v_porch), .v_sync(v_sync), .v_total(v_total),
        .s_valid(s_valid), .s_ready(s_ready), .s_rgb(s_rgb), .s_eol(s_eol), .s_eof(s_eof),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .red(red), .grn(grn), .blu(blu)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // behavioural reference state
    int mh, mv, mst;              // column, line, 0 locked / 1 drain / 2 wait
    logic [23:0] exp_rgb;
    logic        exp_hs, exp_vs;
    logic [95:0] cfg_prev;
    // stream source
    int sx, sy;
    bit gap_now, early_arm;

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic set_cfg(int ha, int hp, int hs, int ht, int va, int vp, int vs, int vt);
        h_active = 12'(ha); h_porch = 12'(hp); h_sync = 12'(hs); h_total = 12'(ht);
        v_active = 12'(va); v_porch = 12'(vp); v_sync = 12'(vs); v_total = 12'(vt);
    endtask

    // One clock: check visible outputs, drive, predict, advance.
    task automatic step(string tag);
        int ha, hp, hs, ht, va, vp, vs, vt;
        bit act, exp_ready, acc, eol_exp;
        string rq;
        logic [95:0] cfg_now;
        chk({tag, " R5 rgb"}, {8'h0, red, grn, blu}, {8'h0, exp_rgb});
        chk({tag, " R1 R2 hsync"}, hsync_n, exp_hs);
        chk({tag, " R1 R3 vsync"}, vsync_n, exp_vs);
        ha = h_active; hp = h_porch; hs = h_sync; ht = h_total;
        va = v_active; vp = v_porch; vs = v_sync; vt = v_total;
        s_valid = !gap_now;
        s_eol   = (sx == ha - 1) || (early_arm && sx == ha - 3);
        s_eof   = (sx == ha - 1) && (sy == va - 1);
        s_rgb   = {8'(sy), 8'(sx), 8'(sx * 7 + sy * 13 + 1)};
        #1;
        cfg_now = {h_active, h_porch, h_sync, h_total, v_active, v_porch, v_sync, v_total};
        if (rst || cfg_now != cfg_prev) begin
            chk({tag, rst ? " R10 ready" : " R9 ready"}, s_ready, 1'b0);
            cfg_prev = cfg_now;
            mh = 0; mv = 0; mst = 0;
            exp_rgb = '0; exp_hs = 1'b1; exp_vs = 1'b1;
        end else begin
            act = (mh < ha) && (mv < va);
            exp_ready = (mst == 0 && act) || (mst == 1);
            rq = (mst == 1) ? " R7 ready" : (mst == 2) ? " R8 ready" : " R4 ready";
            chk({tag, rq}, s_ready, exp_ready);
            acc = s_valid && exp_ready;
            exp_rgb = (acc && mst == 0) ? s_rgb : 24'h0;
            exp_hs = !(mh >= ha + hp && mh < ha + hp + hs);
            exp_vs = !(mv >= va + vp && mv < va + vp + vs);
            eol_exp = (mh == ha - 1);
            if (mst == 0 && acc && (s_eol != eol_exp)) mst = s_eof ? 2 : 1;
            else if (mst == 1 && acc && s_eof)        mst = 2;
            else if (mst == 2 && mh == ht - 1 && mv == vt - 1) mst = 0;
            if (mh == ht - 1) begin
                mh = 0;
                mv = (mv == vt - 1) ? 0 : mv + 1;
            end else mh = mh + 1;
            if (acc) begin
                if (s_eol) begin
                    if (sx != ha - 1) early_arm = 0;
                    sx = 0;
                    sy = (sy >= va - 1) ? 0 : sy + 1;
                end else sx = sx + 1;
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; gap_now = 0; early_arm = 0; sx = 0; sy = 0;
        s_valid = 0; s_eol = 0; s_eof = 0; s_rgb = '0;
        set_cfg(8, 2, 3, 16, 4, 1, 2, 8);
        cfg_prev = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        exp_rgb = '0; exp_hs = 1'b1; exp_vs = 1'b1;
        repeat (3) step("R10 reset");
        rst = 1'b0;

        // clean frames
        repeat (3 * 128) step("R1 R4 clean");

        // a missing beat in mid-line: black slot, no stall, then resync
        for (int c = 0; c < 4 * 128; c++) begin
            gap_now = (c < 128) && (mh == 2) && (mv == 1);
            step("R6 R7 R8 gap");
        end
        gap_now = 0;

        // an early end-of-line marker
        early_arm = 1;
        repeat (4 * 128) step("R7 R8 early eol");
        chk("R7 early marker consumed", early_arm, 1'b0);

        // new timing at a frame boundary
        set_cfg(6, 1, 2, 12, 3, 2, 1, 7);
        sx = 0; sy = 0;
        repeat (3 * 84) step("R9 mode B");

        // timing change in mid-frame
        repeat (37) step("R9 mode B partial");
        set_cfg(8, 2, 3, 16, 4, 1, 2, 8);
        sx = 0; sy = 0;
        repeat (3 * 128) step("R9 mode A again");

        // reset in mid-frame
        repeat (50) step("R4 pre reset");
        rst = 1'b1;
        step("R10 mid reset");
        rst = 1'b0;
        sx = 0; sy = 0;
        repeat (2 * 128) step("R10 after reset");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule